// File: doc/BRIEF.md
# Descriptor Chain Walker

This block is the scatter-gather front end of one DMA channel. It walks a linked chain of 32-byte transfer descriptors held in memory. It reads each descriptor one 32-bit word at a time through a single-outstanding read port, checks the signature in the control word, and turns each valid descriptor into a source/destination/length command on a valid-ready handshake. The data mover that consumes those commands sits downstream and is not part of this block.

A chain is made of runs of descriptors that sit back to back in memory. The walker steps through a run in 32-byte increments. When a run is used up, it jumps to the address held in the last descriptor's next-pointer field. The length of the first run and the chain's head address come from configuration inputs. The length of each later run comes from the descriptor that supplies the pointer.

The walker reports three kinds of event as single-cycle pulses:
- a per-descriptor completion notice,
- a halt, when the chain ends or software withdraws the run request,
- a signature error.

It also keeps a count of the commands the mover has accepted.

Top module: `sg_chain_walker`

## Requirements
- R1: While reset is held, and after it is released, the walker is idle. `busy`, `cmd_valid`, `rd_req_valid` and all three event pulses are low, and `done_count` is 0.
- R2: A walk starts only on a 0-to-1 change of `cfg_run` while idle. That same edge clears `done_count` to 0, and the first read goes to the byte address {cfg_head_hi, cfg_head_lo}. Each read asks for one word, at the descriptor base plus 4 times the word index (0 to 7). A run request that stays high after a walk ends does not start a new one.
- R3: Descriptor words are little-endian and in this order:
  - word 0 is control;
  - word 1 is the byte count;
  - words 2 and 3 are the source address (low, high);
  - words 4 and 5 are the destination address;
  - words 6 and 7 are the next pointer.
  `cmd_len` carries bits 27:0 of word 1. `cmd_src` and `cmd_dst` carry the two 64-bit addresses.
- R4: If control bits 31:16 differ from 0xAD4B, the walker pulses `evt_sig` and returns to idle. It issues no command for that descriptor and reads none of its remaining words.
- R5: After a descriptor's command, if the current run still has descriptors left, the next fetch goes to the current address plus 32. The first run holds `cfg_head_adj` descriptors beyond the head.
- R6: When the run is exhausted, the walker fetches from the next pointer (words 6 and 7). The new run length is taken from bits 13:8 of that same descriptor's control word. Bits 13:8 of every other descriptor are ignored.
- R7: Control bit 0 set means that, once this descriptor's command is accepted, the walker pulses `evt_halt` and goes idle. The halt and signature-error pulses never occur in the same cycle.
- R8: Control bit 1 set means `evt_note` pulses for one cycle right after this descriptor's command is accepted.
- R9: `done_count` increases by exactly one for each accepted command.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command fields do not change and no read request is made. The next descriptor is fetched only after the current command is accepted.
- R11: If `cfg_run` is low when a command is accepted, the walker pulses `evt_halt` and goes idle after that command. A descriptor already being fetched is still read and issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Run request; a rising edge starts a walk, a low level ends it after the current command |
| cfg_head_lo | input | 32 | Low half of the head descriptor address |
| cfg_head_hi | input | 32 | High half of the head descriptor address |
| cfg_head_adj | input | 6 | Number of descriptors following the head in the first run |
| rd_req_valid | output | 1 | One-cycle read request for one word |
| rd_req_addr | output | ADDR_W | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data valid, one pulse per request |
| rd_rsp_data | input | 32 | Read data word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_src | output | ADDR_W | Command source address |
| cmd_dst | output | ADDR_W | Command destination address |
| cmd_len | output | 28 | Command byte count |
| busy | output | 1 | A walk is in progress |
| done_count | output | COUNT_W | Accepted commands since the last start |
| evt_note | output | 1 | Completion-notice pulse |
| evt_halt | output | 1 | Halt pulse (stop flag or run withdrawn) |
| evt_sig | output | 1 | Signature-error pulse |

## Verification
The bench builds the walker with ADDR_W at 64 and COUNT_W at 8. With the full 64-bit address, a nonzero high half of the head address can be seen on the read port, and 64-bit destination values can be seen on the command port. The memory model decodes only ten address bits, so chains of several runs, looping next pointers and a deliberately corrupt control word all fit in a 1 KiB array. Stalls of the mover, both a 30-cycle hold-off and a one-in-four ready pattern, exercise the rules on holding the command and pausing the fetch.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int unsigned SGW_DESC_BYTES = 32;
  localparam int unsigned SGW_WORDS      = 8;
  localparam int unsigned SGW_LEN_W      = 28;
  localparam int unsigned SGW_ADJ_W      = 6;
  localparam logic [15:0] SGW_SIG        = 16'hAD4B;

  typedef struct packed {
    logic [63:0] nxt;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] bytes;
    logic [31:0] ctrl;
  } sgw_desc_t;

  function automatic logic sgw_sig_ok(input logic [31:0] ctrl);
    return ctrl[31:16] == SGW_SIG;
  endfunction

  function automatic logic [SGW_ADJ_W-1:0] sgw_adj(input logic [31:0] ctrl);
    return ctrl[13:8];
  endfunction

  function automatic logic sgw_halt_flag(input logic [31:0] ctrl);
    return ctrl[0];
  endfunction

  function automatic logic sgw_note_flag(input logic [31:0] ctrl);
    return ctrl[1];
  endfunction

  function automatic logic [SGW_LEN_W-1:0] sgw_len(input logic [31:0] bytes);
    return bytes[SGW_LEN_W-1:0];
  endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output sgw_desc_t         desc,
  output logic              desc_ready,
  output logic              sig_bad
);

  localparam int unsigned IDX_W = $clog2(SGW_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SGW_WORDS - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;

  fst_t              st;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       words [SGW_WORDS];
  logic              rsp_take;

  assign rsp_take = (st == F_WAIT) && rd_rsp_valid;

  // one capture register per descriptor word
  for (genvar gi = 0; gi < SGW_WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (rsp_take && idx == IDX_W'(gi)) words[gi] <= rd_rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      idx        <= '0;
      base_q     <= '0;
      desc_ready <= 1'b0;
      sig_bad    <= 1'b0;
    end else begin
      desc_ready <= 1'b0;
      sig_bad    <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          base_q <= base;
          idx    <= '0;
          st     <= F_REQ;
        end
        F_REQ: st <= F_WAIT;
        F_WAIT: if (rd_rsp_valid) begin
          if (idx == '0 && !sgw_sig_ok(rd_rsp_data)) begin
            sig_bad <= 1'b1;
            st      <= F_IDLE;
          end else if (idx == IDX_LAST) begin
            desc_ready <= 1'b1;
            st         <= F_IDLE;
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == F_REQ);
  assign rd_req_addr  = base_q + ADDR_W'({idx, 2'b00});

  always_comb begin
    desc.ctrl  = words[0];
    desc.bytes = words[1];
    desc.src   = {words[3], words[2]};
    desc.dst   = {words[5], words[4]};
    desc.nxt   = {words[7], words[6]};
  end

  // a request is always followed by a wait cycle: single outstanding read
  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> !rd_req_valid);

  assert_sig_vs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sig_bad && desc_ready));

endmodule

// File: rtl/sgw_cmd.sv
module sgw_cmd
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ADDR_W-1:0]    src,
  input  logic [ADDR_W-1:0]    dst,
  input  logic [SGW_LEN_W-1:0] len,
  input  logic                 cmd_ready,
  output logic                 cmd_valid,
  output logic [ADDR_W-1:0]    cmd_src,
  output logic [ADDR_W-1:0]    cmd_dst,
  output logic [SGW_LEN_W-1:0] cmd_len,
  output logic                 accept
);

  assign accept = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_src   <= '0;
      cmd_dst   <= '0;
      cmd_len   <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_src   <= src;
      cmd_dst   <= dst;
      cmd_len   <= len;
    end else if (accept) begin
      cmd_valid <= 1'b0;
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)));

endmodule

// File: rtl/sgw_seq.sv
module sgw_seq
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned COUNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [SGW_ADJ_W-1:0] cfg_adj,
  input  logic                 desc_ready,
  input  logic                 sig_bad,
  input  logic [SGW_ADJ_W-1:0] d_adj,
  input  logic                 d_halt,
  input  logic                 d_note,
  input  logic [ADDR_W-1:0]    d_next,
  input  logic                 accept,
  output logic                 fetch_start,
  output logic [ADDR_W-1:0]    fetch_base,
  output logic                 busy,
  output logic [COUNT_W-1:0]   done_count,
  output logic                 evt_note,
  output logic                 evt_halt,
  output logic                 evt_sig
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CMD} sst_t;

  sst_t                 st;
  logic                 run_q;
  logic                 run_rise;
  logic [ADDR_W-1:0]    cur_addr;
  logic [ADDR_W-1:0]    nxt_addr;
  logic [SGW_ADJ_W-1:0] remaining;
  logic [SGW_ADJ_W-1:0] nxt_rem;
  logic                 halt_q;
  logic                 note_q;

  assign run_rise   = run && !run_q;
  assign busy       = (st != S_IDLE);
  assign fetch_base = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      run_q       <= 1'b0;
      cur_addr    <= '0;
      nxt_addr    <= '0;
      remaining   <= '0;
      nxt_rem     <= '0;
      halt_q      <= 1'b0;
      note_q      <= 1'b0;
      done_count  <= '0;
      fetch_start <= 1'b0;
      evt_note    <= 1'b0;
      evt_halt    <= 1'b0;
      evt_sig     <= 1'b0;
    end else begin
      run_q       <= run;
      fetch_start <= 1'b0;
      evt_note    <= 1'b0;
      evt_halt    <= 1'b0;
      evt_sig     <= 1'b0;
      case (st)
        S_IDLE: if (run_rise) begin
          done_count  <= '0;
          cur_addr    <= cfg_base;
          remaining   <= cfg_adj;
          fetch_start <= 1'b1;
          st          <= S_FETCH;
        end
        S_FETCH: begin
          if (sig_bad) begin
            evt_sig <= 1'b1;
            st      <= S_IDLE;
          end else if (desc_ready) begin
            halt_q <= d_halt;
            note_q <= d_note;
            if (remaining != '0) begin
              nxt_addr <= cur_addr + ADDR_W'(SGW_DESC_BYTES);
              nxt_rem  <= remaining - SGW_ADJ_W'(1);
            end else begin
              nxt_addr <= d_next;
              nxt_rem  <= d_adj;
            end
            st <= S_CMD;
          end
        end
        S_CMD: if (accept) begin
          done_count <= done_count + COUNT_W'(1);
          evt_note   <= note_q;
          if (halt_q || !run) begin
            evt_halt <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cur_addr    <= nxt_addr;
            remaining   <= nxt_rem;
            fetch_start <= 1'b1;
            st          <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done_count == COUNT_W'($past(done_count) + COUNT_W'(1)));

  assert_restart_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && run_rise) |=> (done_count == '0 && fetch_start));

  assert_sig_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sig |-> !busy);

  assert_halt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_halt |-> !busy);

  assert_evt_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_halt, evt_sig}));

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned COUNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_run,
  input  logic [31:0]          cfg_head_lo,
  input  logic [31:0]          cfg_head_hi,
  input  logic [5:0]           cfg_head_adj,
  output logic                 rd_req_valid,
  output logic [ADDR_W-1:0]    rd_req_addr,
  input  logic                 rd_rsp_valid,
  input  logic [31:0]          rd_rsp_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [ADDR_W-1:0]    cmd_src,
  output logic [ADDR_W-1:0]    cmd_dst,
  output logic [27:0]          cmd_len,
  output logic                 busy,
  output logic [COUNT_W-1:0]   done_count,
  output logic                 evt_note,
  output logic                 evt_halt,
  output logic                 evt_sig
);

  logic [63:0]       head_full;
  logic              fetch_start;
  logic [ADDR_W-1:0] fetch_base;
  sgw_desc_t         desc;
  logic              desc_ready;
  logic              sig_bad;
  logic              accept;
  logic              sgw_unused_bits;

  assign head_full       = {cfg_head_hi, cfg_head_lo};
  assign sgw_unused_bits = ^{desc.ctrl[31:14], desc.ctrl[7:2], desc.bytes[31:28]};

  sgw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (fetch_start),
    .base         (fetch_base),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .desc         (desc),
    .desc_ready   (desc_ready),
    .sig_bad      (sig_bad)
  );

  sgw_seq #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (cfg_run),
    .cfg_base    (head_full[ADDR_W-1:0]),
    .cfg_adj     (cfg_head_adj),
    .desc_ready  (desc_ready),
    .sig_bad     (sig_bad),
    .d_adj       (sgw_adj(desc.ctrl)),
    .d_halt      (sgw_halt_flag(desc.ctrl)),
    .d_note      (sgw_note_flag(desc.ctrl)),
    .d_next      (desc.nxt[ADDR_W-1:0]),
    .accept      (accept),
    .fetch_start (fetch_start),
    .fetch_base  (fetch_base),
    .busy        (busy),
    .done_count  (done_count),
    .evt_note    (evt_note),
    .evt_halt    (evt_halt),
    .evt_sig     (evt_sig)
  );

  sgw_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (desc_ready),
    .src       (desc.src[ADDR_W-1:0]),
    .dst       (desc.dst[ADDR_W-1:0]),
    .len       (sgw_len(desc.bytes)),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .cmd_len   (cmd_len),
    .accept    (accept)
  );

  // R10: no word read while a command waits for the mover
  assert_no_fetch_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rd_req_valid);

endmodule

// File: tb/tb_sg_chain_walker.sv
module tb_sg_chain_walker;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_run;
  logic [31:0]   cfg_head_lo, cfg_head_hi;
  logic [5:0]    cfg_head_adj;
  logic          rd_req_valid;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid;
  logic [31:0]   rd_rsp_data;
  logic          cmd_valid, cmd_ready;
  logic [AW-1:0] cmd_src, cmd_dst;
  logic [27:0]   cmd_len;
  logic          busy;
  logic [CW-1:0] done_count;
  logic          evt_note, evt_halt, evt_sig;

  sg_chain_walker #(.ADDR_W(AW), .COUNT_W(CW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0]   mem [0:255];
  logic [155:0]  exp_q [$];
  int n_checks = 0, n_fail = 0;
  int note_n, halt_n, sig_n, req_n, hold_viol;
  int stall_left = 0, ready_mode = 0, cyc = 0;
  bit stall_arm = 0, first_seen = 0, rsp_pend = 0, prev_pend = 0, done_flag = 0;
  logic [AW-1:0]  first_addr, pend_addr;
  logic [155:0]   prev_cmd;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [7:0] flags, input logic [5:0] adj);
    return {16'hAD4B, 2'b00, adj, flags};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] ctrl, input logic [31:0] bytes,
                          input logic [63:0] src, input logic [63:0] dst, input logic [63:0] nxt);
    int i;
    i = a / 4;
    mem[i]   = ctrl;       mem[i+1] = bytes;
    mem[i+2] = src[31:0];  mem[i+3] = src[63:32];
    mem[i+4] = dst[31:0];  mem[i+5] = dst[63:32];
    mem[i+6] = nxt[31:0];  mem[i+7] = nxt[63:32];
  endtask

  // driver side of the scoreboard
  task automatic expect_cmd(input logic [63:0] src, input logic [63:0] dst, input logic [31:0] bytes);
    logic [31:0] trimmed;
    trimmed = bytes & 32'h0FFF_FFFF;
    exp_q.push_back({src, dst, trimmed[27:0]});
  endtask

  task automatic start_chain(input logic [31:0] lo, input logic [31:0] hi, input logic [5:0] adj);
    @(negedge clk);
    cfg_head_lo = lo; cfg_head_hi = hi; cfg_head_adj = adj;
    note_n = 0; halt_n = 0; sig_n = 0; req_n = 0; hold_viol = 0; first_seen = 0;
    cfg_run = 1'b1;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // environment: memory model, mover ready, monitor
  initial begin
    forever begin
      logic rdy;
      logic [155:0] item;
      @(negedge clk);
      if (evt_note) note_n++;
      if (evt_halt) halt_n++;
      if (evt_sig)  sig_n++;
      if (rsp_pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[pend_addr[9:2]];
        rsp_pend     = 0;
      end else begin
        rd_rsp_valid = 1'b0;
      end
      if (rd_req_valid) begin
        pend_addr = rd_req_addr;
        rsp_pend  = 1;
        req_n++;
        if (!first_seen) begin first_addr = rd_req_addr; first_seen = 1; end
        if (cmd_valid) hold_viol++;
      end
      if (prev_pend && (!cmd_valid || {cmd_src, cmd_dst, cmd_len} != prev_cmd)) hold_viol++;
      if (cmd_valid && stall_arm) begin stall_left = 30; stall_arm = 0; end
      if (stall_left > 0) begin rdy = 1'b0; stall_left--; end
      else if (ready_mode == 1) rdy = (cyc % 4 == 3);
      else rdy = 1'b1;
      cyc++;
      if (cmd_valid && rdy) begin
        if (exp_q.size() == 0) begin
          chk("R3/R5/R6", "unexpected command src", cmd_src, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          item = exp_q.pop_front();
          chk("R3/R5/R6", "cmd_src", cmd_src, item[155:92]);
          chk("R3/R5/R6", "cmd_dst", cmd_dst, item[91:28]);
          chk("R3", "cmd_len", {36'd0, cmd_len}, {36'd0, item[27:0]});
        end
      end
      prev_pend = cmd_valid && !rdy;
      prev_cmd  = {cmd_src, cmd_dst, cmd_len};
      cmd_ready = rdy;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int snap;
    rst_n = 1'b0; cfg_run = 1'b0; cfg_head_lo = '0; cfg_head_hi = '0; cfg_head_adj = '0;
    rd_rsp_valid = 1'b0; rd_rsp_data = '0; cmd_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;

    // chain A: run of 3, then a run of 2 through the next pointer
    put_desc(32'h000, mk_ctrl(8'h00, 6'd7), 32'h40,        64'hA000_0000_0000_1000, 64'hB000_0000, 64'h3E0);
    put_desc(32'h020, mk_ctrl(8'h02, 6'd0), 32'hF123_4567, 64'h2000,                64'hB000_1000, 64'h0);
    put_desc(32'h040, mk_ctrl(8'h00, 6'd1), 32'h80,        64'h3000,                64'hB000_2000, 64'h100);
    put_desc(32'h100, mk_ctrl(8'h00, 6'd0), 32'h10,        64'h4000,                64'hC000_0000_0000_0000, 64'h1C0);
    put_desc(32'h120, mk_ctrl(8'h03, 6'd0), 32'h20,        64'h5000,                64'hB000_4000, 64'h0);
    // chain B: second descriptor carries a bad signature
    put_desc(32'h200, mk_ctrl(8'h00, 6'd0), 32'h8,  64'h6000, 64'h7000, 64'h0);
    put_desc(32'h220, 32'h1234_0003,        32'h8,  64'h6100, 64'h7100, 64'h0);
    // chain C: endless loop of single-descriptor runs
    put_desc(32'h300, mk_ctrl(8'h00, 6'd0), 32'h11, 64'h8000, 64'h9000, 64'h340);
    put_desc(32'h340, mk_ctrl(8'h00, 6'd0), 32'h22, 64'h8100, 64'h9100, 64'h380);
    put_desc(32'h380, mk_ctrl(8'h00, 6'd0), 32'h33, 64'h8200, 64'h9200, 64'h300);

    repeat (4) @(negedge clk);
    chk("R1", "busy in reset", {63'd0, busy}, 64'd0);
    chk("R1", "cmd_valid in reset", {63'd0, cmd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_req_valid after reset", {63'd0, rd_req_valid}, 64'd0);
    chk("R1", "done_count after reset", {56'd0, done_count}, 64'd0);
    chk("R1", "events after reset", {61'd0, evt_note, evt_halt, evt_sig}, 64'd0);

    // chain A with a 30-cycle stall on the first command
    ready_mode = 0; stall_arm = 1;
    expect_cmd(64'hA000_0000_0000_1000, 64'hB000_0000, 32'h40);
    expect_cmd(64'h2000, 64'hB000_1000, 32'hF123_4567);
    expect_cmd(64'h3000, 64'hB000_2000, 32'h80);
    expect_cmd(64'h4000, 64'hC000_0000_0000_0000, 32'h10);
    expect_cmd(64'h5000, 64'hB000_4000, 32'h20);
    start_chain(32'h0, 32'h0, 6'd2);
    wait_idle();
    chk("R9", "count after chain A", {56'd0, done_count}, 64'd5);
    chk("R8", "completion pulses A", 64'(note_n), 64'd2);
    chk("R7", "halt pulses A", 64'(halt_n), 64'd1);
    chk("R4", "sig pulses A", 64'(sig_n), 64'd0);
    chk("R5 R6", "leftover expected A", 64'(exp_q.size()), 64'd0);
    chk("R2", "first read address A", first_addr, 64'h0);
    chk("R10", "hold or fetch violations A", 64'(hold_viol), 64'd0);
    chk("R2", "reads for 5 descriptors", 64'(req_n), 64'd40);
    snap = req_n;
    repeat (20) @(negedge clk);
    chk("R2", "no restart with run held", 64'(req_n - snap), 64'd0);
    chk("R2", "idle with run held", {63'd0, busy}, 64'd0);
    cfg_run = 1'b0;
    repeat (2) @(negedge clk);

    // chain B: signature error, high address half, throttled mover
    ready_mode = 1;
    expect_cmd(64'h6000, 64'h7000, 32'h8);
    start_chain(32'h200, 32'h1, 6'd3);
    @(negedge clk);
    chk("R2", "count cleared at start", {56'd0, done_count}, 64'd0);
    wait_idle();
    chk("R9", "count after chain B", {56'd0, done_count}, 64'd1);
    chk("R4", "sig pulses B", 64'(sig_n), 64'd1);
    chk("R4", "reads stop at bad word", 64'(req_n), 64'd9);
    chk("R7", "halt pulses B", 64'(halt_n), 64'd0);
    chk("R2", "first read address B", first_addr, 64'h1_0000_0200);
    chk("R4", "leftover expected B", 64'(exp_q.size()), 64'd0);
    chk("R10", "hold or fetch violations B", 64'(hold_viol), 64'd0);
    cfg_run = 1'b0;
    repeat (2) @(negedge clk);

    // chain C: run withdrawn after the first accepted command
    ready_mode = 0;
    expect_cmd(64'h8000, 64'h9000, 32'h11);
    expect_cmd(64'h8100, 64'h9100, 32'h22);
    start_chain(32'h300, 32'h0, 6'd0);
    @(negedge clk);
    while (done_count != 1) @(negedge clk);
    cfg_run = 1'b0;
    wait_idle();
    chk("R11", "count after withdraw", {56'd0, done_count}, 64'd2);
    chk("R11", "halt pulses C", 64'(halt_n), 64'd1);
    chk("R11", "leftover expected C", 64'(exp_q.size()), 64'd0);
    chk("R8", "no completion pulses C", 64'(note_n), 64'd0);

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule